// File: doc/BRIEF.md
# Swept Sensor Frame Capture Controller

This block sits on the host side of a swept linear image sensor that delivers two 4-bit pixels per clock pulse. It generates the sensor's reset, clock, output-enable and heater-enable pins from the system clock. It also turns the pixel bytes the sensor returns into a stream of bytes, with start-of-frame and end-of-frame markers. The sensor clock comes from a programmable half-period divider. Each frame is read with exactly 1124 sensor clock pulses. Frame starts are held to a fixed period counted in sensor clock slots, so the sensor's integration time stays regular even though the clock is parked between frames.

After a start command the controller runs a fixed power-up sequence. It holds reset high for one slot, releases reset, and sends four pipeline-flush pulses. It then clocks a whole frame whose data is discarded, because the first frame's integration time is wrong. After that it reads frames continuously. A stop command parks the sensor in a low-power nap state at the next rising-edge opportunity. In that state reset is high, the clock is low, outputs are disabled and the heater is off.

States: `ST_NAP` (parked) goes to `ST_WAKE` on start. `ST_WAKE` (reset high, one slot) goes to `ST_FLUSH`. `ST_FLUSH` (four pulses) goes to `ST_SKIP`. `ST_SKIP` (discarded frame) and `ST_READ` (captured frame) each last 1124 slots and go to `ST_READ` when the period equals 1124 slots, otherwise to `ST_GAP`. `ST_GAP` (clock parked) goes to `ST_READ` when the period count expires. Every state other than `ST_NAP` goes to `ST_NAP` at the first rising-edge tick after a stop request.

Top module: `sweep_capture_ctrl`

## Requirements
- R1: After system reset, and while in nap, sen_rst=1, sen_clk=0, sen_oe_n=1, sen_heat=0 and st_valid=0.
- R2: A cmd_start in nap drives sen_oe_n low at once and keeps sen_rst high for exactly 2*H system cycles, where H is the effective half-period. After reset is released, 4 flush pulses and one whole discarded frame of 1124 pulses come before the first streamed byte.
- R3: The effective half-period H is cfg_half clamped to [MIN_HALF, MAX_HALF], latched at start. Every high phase of sen_clk lasts exactly H system cycles.
- R4: Each read frame streams exactly 1124 bytes. Byte j is the sensor value sampled in the system cycle before the rising sen_clk edge that follows pulse j+1 of that frame, packed with the odd nibble in st_data[7:4] and the even nibble in st_data[3:0].
- R5: st_sof is set with the first byte of a frame only, and st_eof with byte 1123 only. Neither marker is set without st_valid.
- R6: Consecutive read frames start exactly P*2*H system cycles apart, where P is the effective period in slots. The sensor clock stays low in the idle slots between frames.
- R7: If cfg_period is below 1124 at start, cfg_err is set and P=1124 is used. Otherwise P=cfg_period and cfg_err is cleared.
- R8: sen_rst is low on every rising sen_clk edge.
- R9: sen_oe_n changes only when at least OE_QUIET system cycles have passed since the last falling sen_clk edge.
- R10: A cmd_stop parks the pins in the nap state (R1) at the next rising-edge tick. A frame that is cut short produces no st_eof and no further bytes.
- R11: Outside nap, sen_heat follows heat_req. In nap it is low.
- R12: cmd_start is ignored while the controller is not in nap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | HALF_W | Requested sensor clock half-period in system cycles |
| cfg_period | input | PER_W | Requested frame period in sensor clock slots |
| cmd_start | input | 1 | Start the power-up sequence (nap only) |
| cmd_stop | input | 1 | Request entry into nap |
| heat_req | input | 1 | Heater request passed to the sensor outside nap |
| pix_odd | input | 4 | Odd-pixel nibble from the sensor |
| pix_even | input | 4 | Even-pixel nibble from the sensor |
| sen_rst | output | 1 | Sensor reset |
| sen_clk | output | 1 | Sensor clock |
| sen_oe_n | output | 1 | Sensor output enable, active low |
| sen_heat | output | 1 | Sensor heater enable |
| st_valid | output | 1 | Stream byte valid (one cycle) |
| st_data | output | 8 | Stream byte, {odd, even} |
| st_sof | output | 1 | First byte of a frame |
| st_eof | output | 1 | Last byte of a frame |
| cfg_err | output | 1 | Frame period was too short and was raised to 1124 |

## Verification
The assertions assume that MIN_HALF is at least OE_QUIET and at least 1, and that the configuration inputs matter only in the cycle a start is accepted. The bench changes cfg_half and cfg_period only while the controller is in nap and uses a minimum half-period above the quiet window. The quiet-window, clock-width and reset-while-clocking properties therefore depend only on the controller's own sequencing. The pixel inputs come from a sensor model that counts rising clock edges since reset was released. They change only after a rising sensor edge, so a sampled byte is always settled and its value shows exactly how many pulses were issued.

// File: rtl/sweep_cap_pkg.sv
package sweep_cap_pkg;
    typedef enum logic [2:0] {
        ST_NAP,
        ST_WAKE,
        ST_FLUSH,
        ST_SKIP,
        ST_READ,
        ST_GAP
    } cap_state_t;
endpackage

// File: rtl/sweep_tick_gen.sv
module sweep_tick_gen #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              rise_tk,
    output logic              end_tk
);
    logic [HALF_W-1:0] ph;
    logic              phase;
    logic              tick;

    assign tick    = run && (ph == half - HALF_W'(1));
    assign rise_tk = tick && !phase;
    assign end_tk  = tick && phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= '0;
            phase <= 1'b0;
        end else if (!run) begin
            ph    <= '0;
            phase <= 1'b0;
        end else if (tick) begin
            ph    <= '0;
            phase <= !phase;
        end else begin
            ph <= ph + HALF_W'(1);
        end
    end

    // R3
    ph_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ph < half);
endmodule

// File: rtl/sweep_byte_cap.sv
module sweep_byte_cap #(
    parameter int FRAME_BYTES = 1124
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_tk,
    input  logic       frame_go,
    input  logic       abort,
    input  logic [3:0] pix_odd,
    input  logic [3:0] pix_even,
    output logic       st_valid,
    output logic [7:0] st_data,
    output logic       st_sof,
    output logic       st_eof
);
    localparam int BYTE_W = $clog2(FRAME_BYTES);
    localparam logic [BYTE_W-1:0] LAST = BYTE_W'(FRAME_BYTES - 1);

    logic              cap_act;
    logic [BYTE_W-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_act  <= 1'b0;
            bcnt     <= '0;
            st_valid <= 1'b0;
            st_data  <= '0;
            st_sof   <= 1'b0;
            st_eof   <= 1'b0;
        end else if (abort) begin
            cap_act  <= 1'b0;
            st_valid <= 1'b0;
            st_sof   <= 1'b0;
            st_eof   <= 1'b0;
        end else if (rise_tk) begin
            st_valid <= cap_act;
            st_data  <= {pix_odd, pix_even};
            st_sof   <= cap_act && (bcnt == '0);
            st_eof   <= cap_act && (bcnt == LAST);
            if (frame_go) begin
                cap_act <= 1'b1;
                bcnt    <= '0;
            end else if (cap_act) begin
                if (bcnt == LAST) cap_act <= 1'b0;
                else              bcnt    <= bcnt + BYTE_W'(1);
            end
        end else begin
            st_valid <= 1'b0;
            st_sof   <= 1'b0;
            st_eof   <= 1'b0;
        end
    end

    // R5
    marker_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_sof || st_eof) |-> st_valid);
    // R5
    markers_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_sof && st_eof));
endmodule

// File: rtl/sweep_capture_ctrl.sv
module sweep_capture_ctrl
    import sweep_cap_pkg::*;
#(
    parameter int FRAME_BYTES  = 1124,
    parameter int FLUSH_PULSES = 4,
    parameter int HALF_W       = 8,
    parameter int PER_W        = 16,
    parameter int MIN_HALF     = 13,
    parameter int MAX_HALF     = 50,
    parameter int OE_QUIET     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              heat_req,
    input  logic [3:0]        pix_odd,
    input  logic [3:0]        pix_even,
    output logic              sen_rst,
    output logic              sen_clk,
    output logic              sen_oe_n,
    output logic              sen_heat,
    output logic              st_valid,
    output logic [7:0]        st_data,
    output logic              st_sof,
    output logic              st_eof,
    output logic              cfg_err
);
    localparam logic [PER_W-1:0]  FRAME_P = PER_W'(FRAME_BYTES);
    localparam logic [PER_W-1:0]  FLUSH_P = PER_W'(FLUSH_PULSES);
    localparam logic [HALF_W-1:0] HMIN    = HALF_W'(MIN_HALF);
    localparam logic [HALF_W-1:0] HMAX    = HALF_W'(MAX_HALF);

    cap_state_t        state, state_nx;
    logic [PER_W-1:0]  scnt, per_q;
    logic [HALF_W-1:0] half_q, half_in;
    logic              stop_pend, rise_tk, end_tk, go_nap, wrap, frame_go, pulsing;

    assign half_in  = (cfg_half < HMIN) ? HMIN : ((cfg_half > HMAX) ? HMAX : cfg_half);
    assign go_nap   = rise_tk && stop_pend && (state != ST_NAP);
    assign pulsing  = (state == ST_FLUSH) || (state == ST_SKIP) || (state == ST_READ);
    assign frame_go = rise_tk && (state == ST_READ) && (scnt == '0) && !stop_pend;

    sweep_tick_gen #(.HALF_W(HALF_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(state != ST_NAP), .half(half_q),
        .rise_tk(rise_tk), .end_tk(end_tk)
    );

    sweep_byte_cap #(.FRAME_BYTES(FRAME_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .rise_tk(rise_tk), .frame_go(frame_go),
        .abort(go_nap), .pix_odd(pix_odd), .pix_even(pix_even),
        .st_valid(st_valid), .st_data(st_data), .st_sof(st_sof), .st_eof(st_eof)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NAP:   if (cmd_start) state_nx = ST_WAKE;
            ST_WAKE:  if (go_nap) state_nx = ST_NAP;
                      else if (end_tk) state_nx = ST_FLUSH;
            ST_FLUSH: if (go_nap) state_nx = ST_NAP;
                      else if (end_tk && scnt == FLUSH_P - PER_W'(1)) state_nx = ST_SKIP;
            ST_SKIP, ST_READ:
                      if (go_nap) state_nx = ST_NAP;
                      else if (end_tk && scnt == FRAME_P - PER_W'(1))
                          state_nx = (per_q == FRAME_P) ? ST_READ : ST_GAP;
            ST_GAP:   if (go_nap) state_nx = ST_NAP;
                      else if (end_tk && scnt == per_q - PER_W'(1)) state_nx = ST_READ;
            default:  state_nx = ST_NAP;
        endcase
    end

    assign wrap = end_tk && ((state_nx != state) ? (state_nx != ST_GAP)
                                                 : (state == ST_READ && scnt == FRAME_P - PER_W'(1)));

    // state register, slot counter and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_NAP;
            scnt      <= '0;
            stop_pend <= 1'b0;
            half_q    <= HMIN;
            per_q     <= FRAME_P;
            cfg_err   <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_NAP)  scnt <= '0;
            else if (wrap)           scnt <= '0;
            else if (end_tk)         scnt <= scnt + PER_W'(1);
            if (state_nx == ST_NAP)  stop_pend <= 1'b0;
            else if (cmd_stop)       stop_pend <= 1'b1;
            if (state == ST_NAP && cmd_start) begin
                half_q  <= half_in;
                per_q   <= (cfg_period < FRAME_P) ? FRAME_P : cfg_period;
                cfg_err <= (cfg_period < FRAME_P);
            end
        end
    end

    // sensor pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sen_rst  <= 1'b1;
            sen_clk  <= 1'b0;
            sen_oe_n <= 1'b1;
            sen_heat <= 1'b0;
        end else begin
            sen_rst  <= (state_nx == ST_NAP) || (state_nx == ST_WAKE);
            sen_oe_n <= (state_nx == ST_NAP);
            sen_heat <= (state_nx != ST_NAP) && heat_req;
            if (state_nx == ST_NAP)        sen_clk <= 1'b0;
            else if (rise_tk && pulsing)   sen_clk <= 1'b1;
            else if (end_tk)               sen_clk <= 1'b0;
        end
    end

    // checker counters
    logic [7:0]      quiet_cnt;
    logic            clk_prev;
    logic [HALF_W:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= 8'hFF;
            clk_prev  <= 1'b0;
            hi_cnt    <= '0;
        end else begin
            clk_prev <= sen_clk;
            if (clk_prev && !sen_clk)   quiet_cnt <= 8'd1;
            else if (quiet_cnt != 8'hFF) quiet_cnt <= quiet_cnt + 8'd1;
            hi_cnt <= sen_clk ? hi_cnt + 1'b1 : '0;
        end
    end

    // R8
    rst_low_clocking_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_clk) |-> !sen_rst);
    // R9
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sen_oe_n) |-> quiet_cnt >= 8'(OE_QUIET));
    // R3
    high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sen_clk) |-> hi_cnt == {1'b0, half_q});
    // R7
    err_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> per_q == FRAME_P);
    // R1
    nap_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NAP && $past(state == ST_NAP)) |-> (sen_rst && sen_oe_n && !sen_clk && !sen_heat));
endmodule

// File: tb/sim_sweep_capture_ctrl.sv
module sim_sweep_capture_ctrl;
    localparam int MINH = 6;
    localparam int MAXH = 50;
    localparam int FB   = 1124;

    logic clk = 0, rst_n = 0;
    logic [7:0]  cfg_half = 8'd6;
    logic [15:0] cfg_period = 16'd1200;
    logic cmd_start = 0, cmd_stop = 0, heat_req = 0;
    logic [3:0] pix_odd, pix_even;
    logic sen_rst, sen_clk, sen_oe_n, sen_heat, st_valid, st_sof, st_eof, cfg_err;
    logic [7:0] st_data;

    always #10 clk = ~clk;

    sweep_capture_ctrl #(.MIN_HALF(MINH), .MAX_HALF(MAXH), .OE_QUIET(5)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_period(cfg_period),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .heat_req(heat_req),
        .pix_odd(pix_odd), .pix_even(pix_even), .sen_rst(sen_rst), .sen_clk(sen_clk),
        .sen_oe_n(sen_oe_n), .sen_heat(sen_heat), .st_valid(st_valid), .st_data(st_data),
        .st_sof(st_sof), .st_eof(st_eof), .cfg_err(cfg_err)
    );

    // sensor model: byte = number of rising clock edges since reset release
    int rises = 0;
    always @(posedge sen_clk or posedge sen_rst)
        if (sen_rst) rises <= 0; else rises <= rises + 1;
    assign pix_odd  = rises[7:4];
    assign pix_even = rises[3:0];

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitors, sampled on the falling system clock edge
    int cyc = 0, fall_cyc = -1000, hi = 0, exp_half = MINH, exp_space = 0;
    int hi_bad = 0, oe_bad = 0, rst_bad = 0, nvalid = 0, frames = 0, rf = 0;
    int j = 0, data_bad = 0, first_act = 0, first_exp = 0, sof_cyc = 0, mark_bad = 0;
    bit have_sof = 0, in_frame = 0;
    logic prev_clk = 0, prev_oe = 1;
    always @(negedge clk) begin
        cyc++;
        if (sen_clk) hi++;
        else begin
            if (hi != 0 && hi != exp_half) hi_bad++;
            hi = 0;
        end
        if (prev_clk && !sen_clk) fall_cyc = cyc;
        if (sen_clk && !prev_clk && sen_rst) rst_bad++;
        if (sen_oe_n !== prev_oe && cyc - fall_cyc < 5) oe_bad++;
        prev_clk = sen_clk;
        prev_oe  = sen_oe_n;
        if (st_valid) begin
            nvalid++;
            if (st_sof) begin
                if (have_sof) chk(cyc - sof_cyc == exp_space, "R6 frame spacing", cyc - sof_cyc, exp_space);
                have_sof = 1; sof_cyc = cyc; j = 0; data_bad = 0; in_frame = 1;
            end else begin
                if (!in_frame) mark_bad++;
                j++;
            end
            if (st_data != 8'((4 + FB * (rf + 1) + j + 1) & 255)) begin
                if (data_bad == 0) begin
                    first_act = st_data;
                    first_exp = (4 + FB * (rf + 1) + j + 1) & 255;
                end
                data_bad++;
            end
            if (st_eof) begin
                chk(j == FB - 1, "R5 eof position", j, FB - 1);
                chk(data_bad == 0, "R4 frame data", first_act, first_exp);
                rf++; frames++; in_frame = 0;
            end
        end
    end

    task automatic wait_negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_run(input int h, input int p, output int rst_w);
        @(negedge clk);
        cfg_half = 8'(h); cfg_period = 16'(p);
        rf = 0; have_sof = 0; in_frame = 0;
        cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        rst_w = 0;
        while (sen_rst && rst_w < 1000) begin
            rst_w++;
            @(negedge clk);
        end
    endtask

    task automatic wait_frames(input int k);
        int target = frames + k;
        while (frames < target) @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk); cmd_stop = 1;
        @(negedge clk); cmd_stop = 0;
        wait_negs(2 * MAXH + 4);
    endtask

    task automatic check_nap(input string req);
        chk(sen_rst == 1, {req, " rst high"}, sen_rst, 1);
        chk(sen_clk == 0, {req, " clk low"}, sen_clk, 0);
        chk(sen_oe_n == 1, {req, " oe disabled"}, sen_oe_n, 1);
        chk(sen_heat == 0, {req, " heater off"}, sen_heat, 0);
        chk(st_valid == 0, {req, " no valid"}, st_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 0; wait_negs(3); rst_n = 1; wait_negs(2);
        check_nap("R1");
    endtask

    task automatic t_normal();
        int w, nv, fr;
        heat_req = 1; exp_half = 6; exp_space = 1200 * 2 * 6;
        start_run(6, 1200, w);
        chk(w == 12, "R2 reset high width", w, 12);
        chk(sen_oe_n == 0, "R2 oe enabled", sen_oe_n, 0);
        chk(sen_heat == 1, "R11 heater follows request", sen_heat, 1);
        chk(cfg_err == 0, "R7 no error for long period", cfg_err, 0);
        wait_frames(2);
        @(negedge clk); cmd_start = 1; @(negedge clk); cmd_start = 0;
        fr = frames;
        wait_frames(1);
        chk(frames == fr + 1 && sen_rst == 0, "R12 start ignored while running", frames, fr + 1);
        wait_negs(2000);
        fr = frames;
        stop_run();
        nv = nvalid;
        check_nap("R10");
        wait_negs(3000);
        chk(nvalid == nv, "R10 no bytes after stop", nvalid, nv);
        chk(frames == fr, "R10 cut frame has no eof", frames, fr);
        chk(mark_bad == 0, "R5 first byte carries sof", mark_bad, 0);
    endtask

    task automatic t_short_period();
        int w;
        heat_req = 0; exp_half = MINH; exp_space = FB * 2 * MINH;
        start_run(1, 50, w);
        chk(w == 2 * MINH, "R3 half clamped to minimum", w, 2 * MINH);
        chk(cfg_err == 1, "R7 error for short period", cfg_err, 1);
        chk(sen_heat == 0, "R11 heater low without request", sen_heat, 0);
        wait_frames(2);
        stop_run();
        check_nap("R1");
    endtask

    task automatic t_max_half();
        int w;
        exp_half = MAXH;
        start_run(200, 1200, w);
        chk(w == 2 * MAXH, "R3 half clamped to maximum", w, 2 * MAXH);
        chk(cfg_err == 0, "R7 error cleared on valid start", cfg_err, 0);
        stop_run();
        check_nap("R10");
    endtask

    bit done = 0;
    initial begin
        t_reset();
        t_normal();
        t_short_period();
        t_max_half();
        chk(rst_bad == 0, "R8 reset low on clock rise", rst_bad, 0);
        chk(oe_bad == 0, "R9 oe quiet after falling clock", oe_bad, 0);
        chk(hi_bad == 0, "R3 high phase width", hi_bad, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", frames, -1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule